// File: doc/BRIEF.md
# Hybrid Private/Shared Address Partitioner

This block sits between a processor core and the local memory of one node in a mesh of many identical cores. The node's local memory is cut in two by a boundary value. Words below the boundary form the private region, and words from the boundary up to the top of memory form the shared region. Each core request carries a flag that says whether it is private or shared.

A private request uses its address as a physical word address. It is checked against the boundary and forwarded to the local memory port in the same cycle, so translation adds no delay. A shared request carries a global virtual address, made of a home node number in the upper bits and an offset in the lower bits. It spends one cycle in a translation stage. If the home node is this node, the request goes to the local memory at boundary plus offset. Otherwise it leaves on the network request port with its node and offset unchanged. Requests that fall outside their region get an error response and are not forwarded.

The boundary can be rewritten at runtime when the block is built in dynamic mode. A rewrite is taken only while nothing is in flight. In static mode the boundary is fixed at build time and cannot be rewritten.

Top module: `hsp_partitioner`

## Requirements
- R1: After reset the boundary equals INIT_BOUNDARY, `req_ready` is 1, `busy` is 0, and `mem_valid`, `net_valid` and `err_valid` are 0.
- R2: An accepted private request (`req_shared`=0) whose address is below the boundary drives `mem_valid`=1 in the same cycle. In that cycle `mem_addr` equals the low MEM_AW address bits, and `mem_write`/`mem_wdata` equal the request's. No network request or error is raised.
- R3: An accepted private request whose address (all GVA_W bits, unsigned) is at or above the boundary drives `err_valid`=1 in the same cycle, with no memory or network request.
- R4: An accepted shared request whose node field (the top NODE_W bits of `req_addr`) equals `local_id` is handled one cycle later. If its offset (the low OFF_W bits) is below DEPTH minus the boundary, the block drives `mem_valid`=1 with `mem_addr` = boundary + offset.
- R5: An accepted shared request for the local node whose offset is at or above DEPTH minus the boundary drives `err_valid`=1 one cycle later, with no memory or network request.
- R6: An accepted shared request whose node field differs from `local_id` drives `net_valid`=1 one cycle later, with `net_node`, `net_offset`, `net_write` and `net_wdata` taken from the request. No offset check is made.
- R7: `req_ready` is 0 in the cycle after a shared request is accepted. It is also 0 while MAX_NET network requests are waiting for `net_done`. A request presented while `req_ready` is 0 produces no output.
- R8: `busy` is 1 while a shared request is in the translation stage or any network request lacks its `net_done` pulse. Each `net_done` pulse retires one outstanding request.
- R9: In dynamic mode, `cfg_wr` with `busy`=0 and `cfg_boundary` ≤ DEPTH raises `cfg_accept` in the same cycle. The new boundary applies from the next cycle. A request in the same cycle still uses the old boundary.
- R10: A `cfg_wr` while `busy`=1, or with `cfg_boundary` > DEPTH, gives `cfg_accept`=0 and leaves the boundary unchanged.
- R11: In static mode (STATIC_MODE=1), `cfg_accept` stays 0 and the boundary stays at INIT_BOUNDARY whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| local_id | input | NODE_W | This node's number |
| cfg_wr | input | 1 | Boundary write strobe |
| cfg_boundary | input | MEM_AW+1 | New boundary value |
| cfg_accept | output | 1 | Boundary write taken this cycle |
| busy | output | 1 | Accesses in flight |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Block can take a request |
| req_shared | input | 1 | 1 = shared (virtual), 0 = private (physical) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | NODE_W+OFF_W | Physical address or {node, offset} |
| req_wdata | input | DATA_W | Write data |
| mem_valid | output | 1 | Local memory request |
| mem_write | output | 1 | Local memory write |
| mem_addr | output | MEM_AW | Local memory word address |
| mem_wdata | output | DATA_W | Local memory write data |
| net_valid | output | 1 | Network request |
| net_write | output | 1 | Network write |
| net_node | output | NODE_W | Home node of network request |
| net_offset | output | OFF_W | Offset in home node's shared region |
| net_wdata | output | DATA_W | Network write data |
| net_done | input | 1 | One network request completed |
| err_valid | output | 1 | Error response to the core |

## Verification
Results for private requests, and their errors, are due in the same cycle as the request. The bench therefore drives inputs on the falling edge and samples these results 1 ns later, before the rising edge. Results for shared requests (local memory, network or error) are due one cycle later. They are sampled 1 ns after the next falling edge, once the inputs have been cleared, and the same sample confirms that a private request left nothing behind. `cfg_accept` is sampled in the cycle of the write, and the effect of a new boundary is checked with requests from the following cycle on. Requests issued in the same cycle as a write confirm that the old boundary still applies to them.

// File: rtl/hsp_pkg.sv
// Package: shared types for the hybrid address partitioner.
// Assumes nothing beyond SystemVerilog 2017.
package hsp_pkg;
    // Destination chosen for one request.
    typedef enum logic [1:0] {
        RT_NONE = 2'd0,
        RT_MEM  = 2'd1,
        RT_NET  = 2'd2,
        RT_ERR  = 2'd3
    } route_e;
endpackage

// File: rtl/hsp_bound_reg.sv
// Module: holds the private/shared boundary.
// What it does: takes a new boundary when writes are allowed (dynamic mode),
// nothing is in flight, and the value does not exceed DEPTH.
// Assumes: in static mode the boundary is fixed at INIT_BOUNDARY.
module hsp_bound_reg #(
    parameter int MEM_AW        = 10,
    parameter bit STATIC_MODE   = 1'b0,
    parameter int INIT_BOUNDARY = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [MEM_AW:0]   cfg_value,
    input  logic              busy,
    output logic              cfg_accept,
    output logic [MEM_AW:0]   boundary
);
    localparam int          DEPTH   = 1 << MEM_AW;
    localparam logic [MEM_AW:0] DEPTH_V = (MEM_AW+1)'(DEPTH);
    localparam logic [MEM_AW:0] INIT_V  = (MEM_AW+1)'(INIT_BOUNDARY);

    logic [MEM_AW:0] bound_q;
    logic            writes_allowed;

    // Pick the mode variant: static builds never take writes.
    generate
        if (STATIC_MODE) begin : g_static
            assign writes_allowed = 1'b0;
        end else begin : g_dynamic
            assign writes_allowed = 1'b1;
        end
    endgenerate

    // Decide whether this cycle's write is taken.
    always_comb begin
        cfg_accept = writes_allowed && cfg_wr && !busy && (cfg_value <= DEPTH_V);
    end

    // Boundary register, loaded only on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bound_q <= INIT_V;
        end else if (cfg_accept) begin
            bound_q <= cfg_value;
        end
    end

    assign boundary = bound_q;

    AST_BOUND_MOVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bound_q != $past(bound_q)) |-> $past(!busy && cfg_wr)); // R10

    AST_BOUND_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        bound_q <= DEPTH_V); // R9
endmodule

// File: rtl/hsp_classify.sv
// Module: combinational classification and translation of one request.
// What it does: private addresses are checked against the boundary. Shared
// addresses are split into node and offset, and local ones are checked
// against the shared region size and mapped to boundary + offset.
// Assumes: OFF_W >= MEM_AW, so the low MEM_AW address bits are offset bits.
module hsp_classify
    import hsp_pkg::*;
#(
    parameter int MEM_AW = 10,
    parameter int NODE_W = 4,
    parameter int OFF_W  = 12
) (
    input  logic                      req_shared,
    input  logic [NODE_W+OFF_W-1:0]   req_addr,
    input  logic [MEM_AW:0]           boundary,
    input  logic [NODE_W-1:0]         local_id,
    output route_e                    route,
    output logic [MEM_AW-1:0]         local_addr
);
    localparam int GVA_W = NODE_W + OFF_W;
    localparam int DEPTH = 1 << MEM_AW;
    localparam int CW    = ((GVA_W > MEM_AW) ? GVA_W : MEM_AW) + 1;

    logic [CW-1:0]     addr_x;
    logic [CW-1:0]     bnd_x;
    logic [CW-1:0]     off_x;
    logic [CW-1:0]     room_x;
    logic [NODE_W-1:0] node;

    // Widen operands so compares are exact.
    always_comb begin
        addr_x = CW'(req_addr);
        bnd_x  = CW'(boundary);
        off_x  = CW'(req_addr[OFF_W-1:0]);
        room_x = CW'(DEPTH) - bnd_x;
        node   = req_addr[GVA_W-1 -: NODE_W];
    end

    // Choose the destination and the local word address.
    always_comb begin
        if (!req_shared) begin
            route      = (addr_x < bnd_x) ? RT_MEM : RT_ERR;
            local_addr = req_addr[MEM_AW-1:0];
        end else begin
            local_addr = boundary[MEM_AW-1:0] + req_addr[MEM_AW-1:0];
            if (node != local_id) begin
                route = RT_NET;
            end else if (off_x < room_x) begin
                route = RT_MEM;
            end else begin
                route = RT_ERR;
            end
        end
    end
endmodule

// File: rtl/hsp_xlate_stage.sv
// Module: one-cycle translation register for shared requests.
// What it does: captures the translated result of a shared request and
// presents it for exactly one cycle.
// Assumes: the caller loads at most every other cycle.
module hsp_xlate_stage
    import hsp_pkg::*;
#(
    parameter int MEM_AW = 10,
    parameter int NODE_W = 4,
    parameter int OFF_W  = 12,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  route_e              route_in,
    input  logic [MEM_AW-1:0]   addr_in,
    input  logic [NODE_W-1:0]   node_in,
    input  logic [OFF_W-1:0]    off_in,
    input  logic                write_in,
    input  logic [DATA_W-1:0]   wdata_in,
    output logic                vld,
    output route_e              route,
    output logic [MEM_AW-1:0]   addr,
    output logic [NODE_W-1:0]   node,
    output logic [OFF_W-1:0]    off,
    output logic                write,
    output logic [DATA_W-1:0]   wdata
);
    // Valid flag: set for one cycle per load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= 1'b0;
        end else begin
            vld <= load;
        end
    end

    // Payload registers, updated on load only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route <= RT_NONE;
            addr  <= '0;
            node  <= '0;
            off   <= '0;
            write <= 1'b0;
            wdata <= '0;
        end else if (load) begin
            route <= route_in;
            addr  <= addr_in;
            node  <= node_in;
            off   <= off_in;
            write <= write_in;
            wdata <= wdata_in;
        end
    end

    AST_STAGE_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> !load); // R7
endmodule

// File: rtl/hsp_net_track.sv
// Module: counts network requests that have not yet been completed.
// What it does: increments on each issued request and decrements on each
// completion. A completion with nothing outstanding is ignored.
// Assumes: the caller stops issuing while the count is full.
module hsp_net_track #(
    parameter int MAX_NET = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    input  logic done,
    output logic full,
    output logic idle
);
    localparam int CNT_W = $clog2(MAX_NET + 1);
    localparam logic [CNT_W-1:0] MAX_V = CNT_W'(MAX_NET);

    logic [CNT_W-1:0] cnt_q;
    logic             retire;

    // A completion only counts when something is outstanding.
    always_comb begin
        retire = done && (cnt_q != '0);
    end

    // Outstanding counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (issue && !retire) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (!issue && retire) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign full = (cnt_q == MAX_V);
    assign idle = (cnt_q == '0);

    AST_NET_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= MAX_V); // R7

    AST_NET_DONE_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !issue && !idle) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R8
endmodule

// File: rtl/hsp_partitioner.sv
// Module: hybrid private/shared address partitioner (top).
// What it does: sends private requests straight to local memory after a
// boundary check. Shared requests are translated in one registered cycle
// to local memory, the network port or an error. It also counts network
// requests in flight and manages boundary rewrites.
// Assumes: OFF_W >= MEM_AW, NODE_W + OFF_W > MEM_AW, and INIT_BOUNDARY <= 2**MEM_AW.
module hsp_partitioner
    import hsp_pkg::*;
#(
    parameter int MEM_AW        = 10,
    parameter int NODE_W        = 4,
    parameter int OFF_W         = 12,
    parameter int DATA_W        = 32,
    parameter int MAX_NET       = 4,
    parameter bit STATIC_MODE   = 1'b0,
    parameter int INIT_BOUNDARY = 512
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NODE_W-1:0]       local_id,
    input  logic                    cfg_wr,
    input  logic [MEM_AW:0]         cfg_boundary,
    output logic                    cfg_accept,
    output logic                    busy,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_shared,
    input  logic                    req_write,
    input  logic [NODE_W+OFF_W-1:0] req_addr,
    input  logic [DATA_W-1:0]       req_wdata,
    output logic                    mem_valid,
    output logic                    mem_write,
    output logic [MEM_AW-1:0]       mem_addr,
    output logic [DATA_W-1:0]       mem_wdata,
    output logic                    net_valid,
    output logic                    net_write,
    output logic [NODE_W-1:0]       net_node,
    output logic [OFF_W-1:0]        net_offset,
    output logic [DATA_W-1:0]       net_wdata,
    input  logic                    net_done,
    output logic                    err_valid
);
    localparam int GVA_W = NODE_W + OFF_W;

    logic [MEM_AW:0]   boundary;
    route_e            cls_route;
    logic [MEM_AW-1:0] cls_addr;
    logic              stage_vld;
    route_e            st_route;
    logic [MEM_AW-1:0] st_addr;
    logic [NODE_W-1:0] st_node;
    logic [OFF_W-1:0]  st_off;
    logic              st_write;
    logic [DATA_W-1:0] st_wdata;
    logic              net_full;
    logic              net_idle;
    logic              acc;
    logic              priv_act;

    // Port-level readiness and in-flight status.
    always_comb begin
        req_ready = !stage_vld && !net_full;
        busy      = stage_vld || !net_idle;
        acc       = req_valid && req_ready;
        priv_act  = acc && !req_shared;
    end

    hsp_bound_reg #(
        .MEM_AW        (MEM_AW),
        .STATIC_MODE   (STATIC_MODE),
        .INIT_BOUNDARY (INIT_BOUNDARY)
    ) bound_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_value  (cfg_boundary),
        .busy       (busy),
        .cfg_accept (cfg_accept),
        .boundary   (boundary)
    );

    hsp_classify #(
        .MEM_AW (MEM_AW),
        .NODE_W (NODE_W),
        .OFF_W  (OFF_W)
    ) cls_i (
        .req_shared (req_shared),
        .req_addr   (req_addr),
        .boundary   (boundary),
        .local_id   (local_id),
        .route      (cls_route),
        .local_addr (cls_addr)
    );

    hsp_xlate_stage #(
        .MEM_AW (MEM_AW),
        .NODE_W (NODE_W),
        .OFF_W  (OFF_W),
        .DATA_W (DATA_W)
    ) stage_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (acc && req_shared),
        .route_in (cls_route),
        .addr_in  (cls_addr),
        .node_in  (req_addr[GVA_W-1 -: NODE_W]),
        .off_in   (req_addr[OFF_W-1:0]),
        .write_in (req_write),
        .wdata_in (req_wdata),
        .vld      (stage_vld),
        .route    (st_route),
        .addr     (st_addr),
        .node     (st_node),
        .off      (st_off),
        .write    (st_write),
        .wdata    (st_wdata)
    );

    hsp_net_track #(
        .MAX_NET (MAX_NET)
    ) track_i (
        .clk   (clk),
        .rst_n (rst_n),
        .issue (net_valid),
        .done  (net_done),
        .full  (net_full),
        .idle  (net_idle)
    );

    // Local memory port: the staged shared result or the direct private request.
    always_comb begin
        if (stage_vld) begin
            mem_valid = (st_route == RT_MEM);
            mem_write = st_write;
            mem_addr  = st_addr;
            mem_wdata = st_wdata;
        end else begin
            mem_valid = priv_act && (cls_route == RT_MEM);
            mem_write = req_write;
            mem_addr  = cls_addr;
            mem_wdata = req_wdata;
        end
    end

    // Network port and error response.
    always_comb begin
        net_valid  = stage_vld && (st_route == RT_NET);
        net_write  = st_write;
        net_node   = st_node;
        net_offset = st_off;
        net_wdata  = st_wdata;
        err_valid  = (stage_vld && (st_route == RT_ERR)) ||
                     (priv_act && (cls_route == RT_ERR));
    end

    AST_ONE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_valid, net_valid, err_valid})); // R2

    AST_PRIV_BELOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !stage_vld) |-> ({1'b0, mem_addr} < boundary)); // R2

    AST_SHARED_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_shared) |=> (mem_valid || net_valid || err_valid)); // R4

    AST_NET_FROM_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        net_valid |-> $past(acc && req_shared)); // R6

    AST_NOT_READY_AFTER_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_shared) |=> !req_ready); // R7

    AST_BUSY_WHILE_STAGED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_shared) |=> busy); // R8
endmodule

// File: tb/hsp_partitioner_tb_top.sv
module hsp_partitioner_tb_top;
    localparam int MEM_AW = 4;
    localparam int NODE_W = 2;
    localparam int OFF_W  = 4;
    localparam int DATA_W = 8;
    localparam int MAX_NET = 3;
    localparam int DEPTH = 16;
    localparam int DYN_INIT = 8;
    localparam int STAT_BND = 5;
    localparam logic [1:0] MY_ID = 2'd2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 1'b0;
    logic [MEM_AW:0] cfg_boundary = '0;
    logic req_valid = 1'b0;
    logic req_shared = 1'b0;
    logic req_write = 1'b0;
    logic [5:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic net_done = 1'b0;

    logic d_cfg_accept, d_busy, d_ready, d_mv, d_mw, d_nv, d_nw, d_ev;
    logic [3:0] d_ma, d_no;
    logic [7:0] d_md, d_nd;
    logic [1:0] d_nn;
    logic s_cfg_accept, s_busy, s_ready, s_mv, s_mw, s_nv, s_nw, s_ev;
    logic [3:0] s_ma, s_no;
    logic [7:0] s_md, s_nd;
    logic [1:0] s_nn;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int bnd = DYN_INIT;

    always #2 clk = ~clk;

    hsp_partitioner #(.MEM_AW(MEM_AW), .NODE_W(NODE_W), .OFF_W(OFF_W), .DATA_W(DATA_W),
        .MAX_NET(MAX_NET), .STATIC_MODE(1'b0), .INIT_BOUNDARY(DYN_INIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .local_id(MY_ID), .cfg_wr(cfg_wr),
        .cfg_boundary(cfg_boundary), .cfg_accept(d_cfg_accept), .busy(d_busy),
        .req_valid(req_valid), .req_ready(d_ready), .req_shared(req_shared),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .mem_valid(d_mv), .mem_write(d_mw), .mem_addr(d_ma), .mem_wdata(d_md),
        .net_valid(d_nv), .net_write(d_nw), .net_node(d_nn), .net_offset(d_no),
        .net_wdata(d_nd), .net_done(net_done), .err_valid(d_ev));

    hsp_partitioner #(.MEM_AW(MEM_AW), .NODE_W(NODE_W), .OFF_W(OFF_W), .DATA_W(DATA_W),
        .MAX_NET(MAX_NET), .STATIC_MODE(1'b1), .INIT_BOUNDARY(STAT_BND)) dut_s_i (
        .clk(clk), .rst_n(rst_n), .local_id(MY_ID), .cfg_wr(cfg_wr),
        .cfg_boundary(cfg_boundary), .cfg_accept(s_cfg_accept), .busy(s_busy),
        .req_valid(req_valid), .req_ready(s_ready), .req_shared(req_shared),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .mem_valid(s_mv), .mem_write(s_mw), .mem_addr(s_ma), .mem_wdata(s_md),
        .net_valid(s_nv), .net_write(s_nw), .net_node(s_nn), .net_offset(s_no),
        .net_wdata(s_nd), .net_done(net_done), .err_valid(s_ev));

    // Pack outputs, zeroing fields whose valid is low.
    function automatic logic [30:0] pack(logic mv, logic mw, logic [3:0] ma, logic [7:0] md,
                                         logic nv, logic nw, logic [1:0] nn, logic [3:0] no,
                                         logic [7:0] nd, logic ev);
        return {mv, mv & mw, mv ? ma : 4'd0, mv ? md : 8'd0,
                nv, nv & nw, nv ? nn : 2'd0, nv ? no : 4'd0, nv ? nd : 8'd0, ev};
    endfunction

    function automatic logic [30:0] obs_d();
        return pack(d_mv, d_mw, d_ma, d_md, d_nv, d_nw, d_nn, d_no, d_nd, d_ev);
    endfunction

    function automatic logic [30:0] obs_s();
        return pack(s_mv, s_mw, s_ma, s_md, s_nv, s_nw, s_nn, s_no, s_nd, s_ev);
    endfunction

    // Expected same-cycle (imm) and next-cycle (late) outputs.
    task automatic expect_for(input logic sh, input logic [5:0] a, input logic [7:0] wd,
                              input int b, output logic [30:0] imm, output logic [30:0] late,
                              output string tag);
        int off;
        int node;
        imm = '0;
        late = '0;
        off = int'(a[3:0]);
        node = int'(a[5:4]);
        if (!sh) begin
            if (int'(a) < b) begin
                imm = pack(1'b1, a[0], a[3:0], wd, 1'b0, 1'b0, 2'd0, 4'd0, 8'd0, 1'b0);
                tag = "R2";
            end else begin
                imm = pack(1'b0, 1'b0, 4'd0, 8'd0, 1'b0, 1'b0, 2'd0, 4'd0, 8'd0, 1'b1);
                tag = "R3";
            end
        end else if (node != int'(MY_ID)) begin
            late = pack(1'b0, 1'b0, 4'd0, 8'd0, 1'b1, a[0], a[5:4], a[3:0], wd, 1'b0);
            tag = "R6";
        end else if (off < DEPTH - b) begin
            late = pack(1'b1, a[0], 4'(b + off), wd, 1'b0, 1'b0, 2'd0, 4'd0, 8'd0, 1'b0);
            tag = "R4";
        end else begin
            late = pack(1'b0, 1'b0, 4'd0, 8'd0, 1'b0, 1'b0, 2'd0, 4'd0, 8'd0, 1'b1);
            tag = "R5";
        end
    endtask

    task automatic check(input string tag, input logic [30:0] got, input logic [30:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic check1(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0b expected %0b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic net_drain(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            net_done = 1'b1;
        end
        @(negedge clk);
        net_done = 1'b0;
    endtask

    // One request; checks dynamic and static instances at their due cycles.
    task automatic access(input logic sh, input logic [5:0] a, input bit drain);
        logic [30:0] di, dl, si, sl;
        string dt, st;
        logic [7:0] wd;
        wd = 8'(int'(a) * 5 + 3);
        expect_for(sh, a, wd, bnd, di, dl, dt);
        expect_for(sh, a, wd, STAT_BND, si, sl, st);
        @(negedge clk);
        req_valid = 1'b1;
        req_shared = sh;
        req_write = a[0];
        req_addr = a;
        req_wdata = wd;
        #1;
        check(dt, obs_d(), di);
        check({"R11 ", st}, obs_s(), si);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        check(dt, obs_d(), dl);
        check({"R11 ", st}, obs_s(), sl);
        if (drain && sh && (a[5:4] != MY_ID)) net_drain(1);
    endtask

    task automatic set_bound(input int b, input logic exp_acc);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_boundary = 5'(b);
        #1;
        check1("R9/R10 cfg_accept", d_cfg_accept, exp_acc);
        check1("R11 static cfg_accept", s_cfg_accept, 1'b0);
        @(negedge clk);
        cfg_wr = 1'b0;
        if (exp_acc) bnd = b;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state.
        check("R1 outputs idle", obs_d(), '0);
        check1("R1 req_ready", d_ready, 1'b1);
        check1("R1 busy", d_busy, 1'b0);
        access(1'b0, 6'd7, 1'b1);   // R1: below initial boundary 8
        access(1'b0, 6'd8, 1'b1);   // R1: at initial boundary

        // Sweep every boundary, every private address up to 20, every shared address.
        for (int b = 0; b <= DEPTH; b++) begin
            set_bound(b, 1'b1);
            for (int a = 0; a <= 20; a++) access(1'b0, 6'(a), 1'b1);
            for (int a = 0; a < 64; a++) access(1'b1, 6'(a), 1'b1);
        end

        // R9: write and request in the same cycle; request uses old boundary.
        set_bound(8, 1'b1);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_boundary = 5'd4;
        req_valid = 1'b1;
        req_shared = 1'b0;
        req_write = 1'b0;
        req_addr = 6'd6;
        req_wdata = 8'h5A;
        #1;
        check1("R9 same-cycle accept", d_cfg_accept, 1'b1);
        check("R9 old boundary used", obs_d(),
              pack(1'b1, 1'b0, 4'd6, 8'h5A, 1'b0, 1'b0, 2'd0, 4'd0, 8'd0, 1'b0));
        @(negedge clk);
        cfg_wr = 1'b0;
        req_valid = 1'b0;
        bnd = 4;
        access(1'b0, 6'd6, 1'b1);   // R9: now above new boundary
        access(1'b0, 6'd3, 1'b1);

        // R10/R8: write during a staged shared request and during an outstanding network request.
        @(negedge clk);
        req_valid = 1'b1;
        req_shared = 1'b1;
        req_addr = {2'd0, 4'd1};
        @(negedge clk);
        req_valid = 1'b0;
        cfg_wr = 1'b1;
        cfg_boundary = 5'd12;
        #1;
        check1("R8 busy while staged", d_busy, 1'b1);
        check1("R10 refused while staged", d_cfg_accept, 1'b0);
        @(negedge clk);
        #1;
        check1("R8 busy with net pending", d_busy, 1'b1);
        check1("R10 refused while net pending", d_cfg_accept, 1'b0);
        @(negedge clk);
        cfg_wr = 1'b0;
        net_drain(1);
        #1;
        check1("R8 idle after net_done", d_busy, 1'b0);
        access(1'b0, 6'd4, 1'b1);   // R10: boundary still 4, so error
        set_bound(17, 1'b0);        // R10: value above DEPTH
        access(1'b0, 6'd3, 1'b1);   // R10: boundary still 4

        // R7: fill the network counter, then a request while not ready is ignored.
        for (int i = 0; i < MAX_NET; i++) access(1'b1, {2'd1, 4'(i)}, 1'b0);
        @(negedge clk);
        #1;
        check1("R7 not ready when full", d_ready, 1'b0);
        @(negedge clk);
        req_valid = 1'b1;
        req_shared = 1'b0;
        req_addr = 6'd0;
        #1;
        check("R7 ignored same cycle", obs_d(), '0);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        check("R7 ignored next cycle", obs_d(), '0);
        net_drain(MAX_NET);
        #1;
        check1("R7 ready after drain", d_ready, 1'b1);
        check1("R8 idle after drain", d_busy, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule